// File: doc/BRIEF.md
# Hex Record Stream Loader

The block takes a stream of ASCII characters, one per cycle when `char_valid_i` is high, and parses it as a sequence of text records. Each record carries a program or data image chunk. Every data byte inside a record comes out on a write port as one strobe, with an address and a data value. The block checks every record against its checksum, its trailer and its address order. It recognises the closing record, confirms the number of data records announced there, and raises a one-cycle done pulse when the end-of-transmission character arrives.

A record starts with `;` (0x3B). After that come bytes written as two hex characters each, high nibble first:
- the count,
- the start address high byte,
- the start address low byte,
- the data bytes,
- a 16-bit checksum sent as two bytes, high byte first.

Then come the raw characters CR (0x0D) and LF (0x0A), followed by six NUL (0x00). A record with a count of zero is the closing record. Its address field holds the number of good data records seen. XOFF (0x13) ends the transmission. The loader accepts one character every cycle, so `char_ready_o` is always high once reset is released.

Top module: `hexrec_parser`

## Requirements
- R1: While reset is held and immediately after it, `wr_en_o`, `done_o` and all four error flags are low, and `char_ready_o` is high.
- R2: A byte is formed from two hex characters, high nibble first. Digits `0`-`9`, `A`-`F` and `a`-`f` are all accepted.
- R3: Characters that arrive outside a record, other than `;` and XOFF, are ignored. `;` (0x3B) opens a record.
- R4: Counts from 1 to 24 (0x18) give data records, and count 0 gives the closing record. A count above 24 raises `fmt_err_o`, and the record produces no writes.
- R5: Each data byte produces exactly one `wr_en_o` pulse, one cycle after its second character. The first address is the record's start address, and each following byte goes to the next address. Two write pulses never fall in adjacent cycles.
- R6: The checksum is the 16-bit sum of the count byte, both address bytes and all data bytes. If it mismatches, `cksum_err_o` pulses one cycle after the sixth NUL, and the record is not counted.
- R7: The trailer must be CR (0x0D), then LF (0x0A), then six 0x00 characters. Any other character there raises `fmt_err_o` and drops the record.
- R8: A non-hex character inside the hex part of a record raises `fmt_err_o`. Bytes already written stay written, and the parser waits for the next `;`. A `;` inside a record also raises `fmt_err_o`, and that `;` itself opens a new record.
- R9: A data record is checked for address order when its checksum is good. If its start address is not one past the last byte of the previous good data record, `seq_err_o` pulses and the record is not counted. The first record after reset or after done is exempt.
- R10: When a closing record ends, its address field is compared with the count of good data records, and a mismatch pulses `count_err_o`. A bad checksum on the closing record pulses `cksum_err_o` in that same cycle.
- R11: XOFF (0x13) after a good closing record pulses `done_o` for one cycle, with no error flag, and clears the record count and the address-order history. XOFF at any other time has no effect.
- R12: Every error flag and `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_valid_i | input | 1 | Character present this cycle |
| char_data_i | input | 8 | ASCII character |
| char_ready_o | output | 1 | Character accepted (high out of reset) |
| wr_en_o | output | 1 | Write strobe, one per data byte |
| wr_addr_o | output | 16 | Write address |
| wr_data_o | output | 8 | Write data |
| done_o | output | 1 | End of a good transmission |
| cksum_err_o | output | 1 | Record checksum mismatch |
| fmt_err_o | output | 1 | Illegal character, count or trailer |
| seq_err_o | output | 1 | Record start address out of order |
| count_err_o | output | 1 | Closing record count mismatch |

## Verification
The checksum compare and the record-count compare both resolve on the sixth NUL of a closing record, so `cksum_err_o` and `count_err_o` can rise in the same cycle. The bench provokes this by sending a closing record that carries both a wrong record count and a corrupted checksum. A monitor counts the cycles in which both flags are high together, and the bench expects exactly one such cycle. The bench also expects that the XOFF sent after that record produces no done pulse. A later closing record with both fields correct must pass silently, and its XOFF must produce the done pulse.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;
  localparam logic [7:0] CH_SEMI = 8'h3B;
  localparam logic [7:0] CH_CR   = 8'h0D;
  localparam logic [7:0] CH_LF   = 8'h0A;
  localparam logic [7:0] CH_NUL  = 8'h00;
  localparam logic [7:0] CH_XOFF = 8'h13;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CNT, ST_AHI, ST_ALO, ST_DATA, ST_CKH, ST_CKL, ST_CR, ST_LF, ST_NUL
  } st_e;

  // {ok, nibble}
  function automatic logic [4:0] hex_decode(input logic [7:0] c);
    if (c >= 8'h30 && c <= 8'h39)      hex_decode = {1'b1, c[3:0]};
    else if (c >= 8'h41 && c <= 8'h46) hex_decode = {1'b1, c[3:0] + 4'd9};
    else if (c >= 8'h61 && c <= 8'h66) hex_decode = {1'b1, c[3:0] + 4'd9};
    else                               hex_decode = 5'd0;
  endfunction
endpackage

// File: rtl/hexrec_nib_pair.sv
module hexrec_nib_pair (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       nib_vld_i,
  input  logic [3:0] nib_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o
);
  logic       have_hi_q;
  logic [3:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_hi_q <= 1'b0;
      hi_q      <= '0;
    end else if (clear_i) begin
      have_hi_q <= 1'b0;
    end else if (nib_vld_i) begin
      have_hi_q <= !have_hi_q;
      if (!have_hi_q) hi_q <= nib_i;
    end
  end

  assign byte_vld_o = nib_vld_i && have_hi_q && !clear_i;
  assign byte_o     = {hi_q, nib_i};
endmodule

// File: rtl/hexrec_sum.sv
module hexrec_sum #(
  parameter int SUM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             add_i,
  input  logic [7:0]       byte_i,
  output logic [SUM_W-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_o <= '0;
    else if (clear_i) sum_o <= '0;
    else if (add_i)   sum_o <= sum_o + SUM_W'(byte_i);
  end
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser #(
  parameter int MAX_CNT = 24,
  parameter int NUL_LEN = 6,
  parameter int SUM_W   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        char_valid_i,
  input  logic [7:0]  char_data_i,
  output logic        char_ready_o,
  output logic        wr_en_o,
  output logic [15:0] wr_addr_o,
  output logic [7:0]  wr_data_o,
  output logic        done_o,
  output logic        cksum_err_o,
  output logic        fmt_err_o,
  output logic        seq_err_o,
  output logic        count_err_o
);
  import hexrec_pkg::*;

  localparam int ADDR_W = 16;
  localparam int NUL_W  = $clog2(NUL_LEN + 1);

  st_e               st_q;
  logic [7:0]        cnt_q, rem_q, ck_hi_q;
  logic [ADDR_W-1:0] addr_q, start_q, next_q, rec_cnt_q;
  logic [NUL_W-1:0]  nul_q;
  logic              ck_ok_q, have_prev_q, final_q;

  logic       acc, is_semi, hex_ok, in_hex, nib_vld, byte_vld;
  logic [3:0] nib;
  logic [7:0] byte_v;
  logic [SUM_W-1:0] sum;

  assign char_ready_o = rst_ni;
  assign acc     = char_valid_i && char_ready_o;
  assign is_semi = char_data_i == CH_SEMI;
  assign {hex_ok, nib} = hex_decode(char_data_i);
  assign in_hex  = st_q inside {ST_CNT, ST_AHI, ST_ALO, ST_DATA, ST_CKH, ST_CKL};
  assign nib_vld = acc && in_hex && hex_ok;

  hexrec_nib_pair u_pair (
    .clk_i, .rst_ni,
    .clear_i   (acc && is_semi),
    .nib_vld_i (nib_vld),
    .nib_i     (nib),
    .byte_vld_o(byte_vld),
    .byte_o    (byte_v)
  );

  hexrec_sum #(.SUM_W(SUM_W)) u_sum (
    .clk_i, .rst_ni,
    .clear_i(acc && is_semi),
    .add_i  (byte_vld && !(st_q inside {ST_CKH, ST_CKL})),
    .byte_i (byte_v),
    .sum_o  (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      cnt_q <= '0; rem_q <= '0; ck_hi_q <= '0;
      addr_q <= '0; start_q <= '0; next_q <= '0; rec_cnt_q <= '0;
      nul_q <= '0; ck_ok_q <= 1'b0; have_prev_q <= 1'b0; final_q <= 1'b0;
      wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
      done_o <= 1'b0; cksum_err_o <= 1'b0; fmt_err_o <= 1'b0;
      seq_err_o <= 1'b0; count_err_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0; done_o <= 1'b0; cksum_err_o <= 1'b0;
      fmt_err_o <= 1'b0; seq_err_o <= 1'b0; count_err_o <= 1'b0;
      if (acc) begin
        if (is_semi) begin
          if (st_q != ST_IDLE) fmt_err_o <= 1'b1;
          st_q <= ST_CNT;
        end else begin
          unique case (st_q)
            ST_IDLE: if (char_data_i == CH_XOFF && final_q) begin
              done_o <= 1'b1;
              final_q <= 1'b0;
              rec_cnt_q <= '0;
              have_prev_q <= 1'b0;
            end
            ST_CR: if (char_data_i == CH_CR) st_q <= ST_LF;
                   else begin fmt_err_o <= 1'b1; st_q <= ST_IDLE; end
            ST_LF: if (char_data_i == CH_LF) begin st_q <= ST_NUL; nul_q <= '0; end
                   else begin fmt_err_o <= 1'b1; st_q <= ST_IDLE; end
            ST_NUL: if (char_data_i != CH_NUL) begin
              fmt_err_o <= 1'b1; st_q <= ST_IDLE;
            end else if (nul_q != NUL_W'(NUL_LEN - 1)) begin
              nul_q <= nul_q + 1'b1;
            end else begin
              st_q <= ST_IDLE;
              if (!ck_ok_q) cksum_err_o <= 1'b1;
              if (cnt_q == 8'd0) begin
                if (start_q != rec_cnt_q) count_err_o <= 1'b1;
                else if (ck_ok_q) final_q <= 1'b1;
              end else if (ck_ok_q) begin
                if (have_prev_q && start_q != next_q) seq_err_o <= 1'b1;
                else begin
                  rec_cnt_q <= rec_cnt_q + 1'b1;
                  next_q <= addr_q;
                  have_prev_q <= 1'b1;
                end
              end
            end
            default: if (!hex_ok) begin
              fmt_err_o <= 1'b1; st_q <= ST_IDLE;
            end else if (byte_vld) begin
              unique case (st_q)
                ST_CNT: begin
                  cnt_q <= byte_v;
                  if (byte_v > 8'(MAX_CNT)) begin fmt_err_o <= 1'b1; st_q <= ST_IDLE; end
                  else st_q <= ST_AHI;
                end
                ST_AHI: begin addr_q[15:8] <= byte_v; st_q <= ST_ALO; end
                ST_ALO: begin
                  addr_q[7:0] <= byte_v;
                  start_q <= {addr_q[15:8], byte_v};
                  rem_q <= cnt_q;
                  st_q <= (cnt_q == 8'd0) ? ST_CKH : ST_DATA;
                end
                ST_DATA: begin
                  wr_en_o <= 1'b1; wr_addr_o <= addr_q; wr_data_o <= byte_v;
                  addr_q <= addr_q + 1'b1;
                  rem_q <= rem_q - 1'b1;
                  if (rem_q == 8'd1) st_q <= ST_CKH;
                end
                ST_CKH: begin ck_hi_q <= byte_v; st_q <= ST_CKL; end
                ST_CKL: begin ck_ok_q <= ({ck_hi_q, byte_v} == 16'(sum)); st_q <= ST_CR; end
                default: st_q <= ST_IDLE;
              endcase
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/hexrec_parser_chk.sv
module hexrec_parser_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        char_valid_i,
  input logic [7:0]  char_data_i,
  input logic        char_ready_o,
  input logic        wr_en_o,
  input logic [15:0] wr_addr_o,
  input logic [7:0]  wr_data_o,
  input logic        done_o,
  input logic        cksum_err_o,
  input logic        fmt_err_o,
  input logic        seq_err_o,
  input logic        count_err_o
);
  p_wr_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_clean_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(fmt_err_o || cksum_err_o || seq_err_o || count_err_o || wr_en_o));
  p_fmt_no_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |-> !wr_en_o);
  p_seq_good_ck_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> !cksum_err_o && !count_err_o);
  p_ck_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cksum_err_o |=> !cksum_err_o);
  p_cnt_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_err_o |=> !count_err_o);
  p_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_i |-> char_ready_o);
endmodule

bind hexrec_parser hexrec_parser_chk u_chk (.*);

// File: tb/hexrec_parser_tb.sv
module hexrec_parser_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic char_valid_i = 1'b0;
  logic [7:0] char_data_i = 8'h00;
  logic char_ready_o, wr_en_o, done_o, cksum_err_o, fmt_err_o, seq_err_o, count_err_o;
  logic [15:0] wr_addr_o;
  logic [7:0]  wr_data_o;

  hexrec_parser u_dut (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  int n_ck = 0, n_fmt = 0, n_seq = 0, n_cnt = 0, n_done = 0, n_both = 0, n_stuck = 0;
  int exp_ck = 0, exp_fmt = 0, exp_seq = 0, exp_cnt = 0, exp_done = 0;
  logic [23:0] exp_q[$];
  logic [7:0]  payload[0:23];
  logic [4:0]  prev_flags = '0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) if (rst_ni) begin
    logic [4:0] fl;
    fl = {done_o, cksum_err_o, fmt_err_o, seq_err_o, count_err_o};
    if (|(fl & prev_flags)) n_stuck++;
    prev_flags = fl;
    n_done += done_o; n_ck += cksum_err_o; n_fmt += fmt_err_o;
    n_seq += seq_err_o; n_cnt += count_err_o;
    if (cksum_err_o && count_err_o) n_both++;
    if (wr_en_o) begin
      if (exp_q.size() == 0) chk("R5 unexpected write", {8'h0, wr_addr_o}, 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk("R5 write addr/data", {wr_addr_o, wr_data_o}, e);
      end
    end
  end

  function automatic logic [7:0] hexc(input logic [3:0] n, input bit lc);
    if (n < 10) return 8'h30 + 8'(n);
    return (lc ? 8'h57 : 8'h37) + 8'(n);
  endfunction

  task automatic send_ch(input logic [7:0] c);
    char_valid_i = 1'b1;
    char_data_i = c;
    @(negedge clk_i);
    char_valid_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit lc);
    send_ch(hexc(b[7:4], lc));
    send_ch(hexc(b[3:0], lc));
  endtask

  // bad_pos: -1 none, 0 CR, 1 LF, 2..7 NUL
  task automatic send_rec(input logic [7:0] cnt, input logic [15:0] addr, input bit bad_ck,
                          input int bad_pos, input bit lc, input bit semi);
    logic [15:0] s;
    s = 16'(cnt) + 16'(addr[15:8]) + 16'(addr[7:0]);
    if (semi) send_ch(8'h3B);
    send_byte(cnt, lc); send_byte(addr[15:8], lc); send_byte(addr[7:0], lc);
    for (int i = 0; i < int'(cnt); i++) begin
      s += 16'(payload[i]);
      exp_q.push_back({addr + 16'(i), payload[i]});
      send_byte(payload[i], lc);
    end
    if (bad_ck) s += 16'h0101;
    send_byte(s[15:8], lc); send_byte(s[7:0], lc);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] c;
      c = (i == 0) ? 8'h0D : (i == 1) ? 8'h0A : 8'h00;
      if (i == bad_pos) begin send_ch(8'h20); break; end
      send_ch(c);
    end
    repeat (2) @(negedge clk_i);
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int i = 0; i < 24; i++) payload[i] = seed + 8'(i * 37);
  endtask

  task automatic flags(input string req);
    chk({req, " cksum_err count"}, n_ck, exp_ck);
    chk({req, " fmt_err count"}, n_fmt, exp_fmt);
    chk({req, " seq_err count"}, n_seq, exp_seq);
    chk({req, " count_err count"}, n_cnt, exp_cnt);
    chk({req, " done count"}, n_done, exp_done);
    chk({req, " pending writes"}, exp_q.size(), 0);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 outputs in reset", {wr_en_o, done_o, cksum_err_o, fmt_err_o, seq_err_o, count_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready after reset", char_ready_o, 1);
    chk("R1 outputs after reset", {wr_en_o, done_o, cksum_err_o, fmt_err_o, seq_err_o, count_err_o}, 0);

    // R3 stray characters before a record are ignored
    send_ch("Q"); send_ch(8'h0D); send_ch("7");
    fill(8'h11); send_rec(8'd3, 16'h1000, 0, -1, 0, 1);
    flags("R3 R5 first record");
    // R2 R4 max count, lowercase hex
    fill(8'hA5); send_rec(8'd24, 16'h1003, 0, -1, 1, 1);
    flags("R2 R4 max record lowercase");
    // R6 checksum mismatch, writes still issued
    fill(8'h3C); send_rec(8'd2, 16'h101B, 1, -1, 0, 1);
    exp_ck++; flags("R6 bad checksum");
    // R9 address out of order
    fill(8'h77); send_rec(8'd1, 16'h2000, 0, -1, 0, 1);
    exp_seq++; flags("R9 out of order");
    // R4 count 0x19 rejected, then garbage ignored
    send_ch(8'h3B); send_byte(8'h19, 0); send_byte(8'h10, 0); send_byte(8'h1B, 0);
    send_ch("Z"); send_ch("Z");
    repeat (2) @(negedge clk_i);
    exp_fmt++; flags("R4 count too large");
    fill(8'h05); send_rec(8'd2, 16'h101B, 0, -1, 0, 1);
    flags("R3 resync record");
    // R8 non-hex inside data
    payload[0] = 8'h55;
    send_ch(8'h3B); send_byte(8'h04, 0); send_byte(8'h10, 0); send_byte(8'h1D, 0);
    exp_q.push_back({16'h101D, 8'h55});
    send_byte(8'h55, 0); send_ch("G");
    repeat (2) @(negedge clk_i);
    exp_fmt++; flags("R8 non-hex char");
    // R8 semicolon inside a record restarts it
    send_ch(8'h3B); send_byte(8'h01, 0);
    fill(8'h99); send_rec(8'd1, 16'h101D, 0, -1, 0, 1);
    exp_fmt++; flags("R8 semicolon restart");
    // R7 corrupt trailer (LF, then a NUL)
    fill(8'h42); send_rec(8'd1, 16'h101E, 0, 1, 0, 1);
    exp_fmt++; flags("R7 bad LF");
    fill(8'h43); send_rec(8'd1, 16'h101E, 0, 5, 0, 1);
    exp_fmt++; flags("R7 bad NUL");
    // R11 XOFF with no closing record
    send_ch(8'h13); repeat (2) @(negedge clk_i);
    flags("R11 stray XOFF");
    // R10 closing record with wrong count and bad checksum together
    send_rec(8'd0, 16'd7, 1, -1, 0, 1);
    exp_ck++; exp_cnt++;
    flags("R10 bad closing record");
    chk("R10 both flags same cycle", n_both, 1);
    send_ch(8'h13); repeat (2) @(negedge clk_i);
    flags("R11 XOFF after bad closing");
    // R10 R11 good closing record (4 good data records)
    send_rec(8'd0, 16'd4, 0, -1, 0, 1);
    flags("R10 good closing record");
    send_ch(8'h13); repeat (2) @(negedge clk_i);
    exp_done++; flags("R11 done");
    // R9 history cleared by done
    fill(8'h10); send_rec(8'd2, 16'h3000, 0, -1, 0, 1);
    flags("R9 after done");
    chk("R12 single-cycle pulses", n_stuck, 0);
    report();
  end
endmodule